// File: doc/BRIEF.md
# Fixed-Ratio Sine Sample Generator

This block produces a stream of signed sine samples for an external DAC. An address counter steps through a constant sine table, one entry per clock, and wraps at a length that need not be a power of two. With the default settings the clock is 155.52 MHz and the output is 10 MHz. The table is 1944 entries long and holds exactly 125 whole sine periods, so the output frequency is an exact rational fraction of the clock. A phase accumulator would instead truncate its phase, and that truncation produces spurs. This design has no such truncation.

The table is built at elaboration from constant arithmetic. Its read is registered, and the result is then retimed by a second output register on the same clock. This gives the data path a fixed latency that does not drift. A one-bit square wave comes from the sign of the registered sample, so a mixer or a digital phase detector can use the block without a DAC. A strobe marks the sample that begins each table period.

An enable input freezes the whole block. A synchronous reset returns it to the start of the table.

Top module: `sine_synth_fixed`

## Requirements
- R1: On every clock edge with `runEn` high and `syncRst` low, the table address advances by one. Successive output samples follow the table in address order.
- R2: The address counts from 0 to TABLE_LEN-1 (1943 by default) and then returns to 0. Sample 1943 on the output is followed directly by sample 0.
- R3: Table entry n equals round(AMPLITUDE·sin(2π·CYCLES·n/TABLE_LEN)), within one LSB. It is carried as a SAMPLE_W-bit two's complement word. Entries whose exact value is 0 or ±AMPLITUDE match exactly.
- R4: An entry appears on `sampleOut` two enabled edges after the address selects it. After reset, entry 0 is on the output after the second enabled edge. Before that edge, the output keeps its reset value.
- R5: `squareOut` is 1 exactly when `sampleOut` is non-negative, in the same cycle. Over one full table period it is high for as many samples as the table has non-negative entries (973 with the defaults).
- R6: `periodStart` is high exactly in the output steps that carry table entry 0, once per TABLE_LEN enabled edges.
- R7: While `runEn` is low, `sampleOut`, `squareOut` and `periodStart` all keep their values.
- R8: A clock edge with `syncRst` high clears the address to 0 and sets `sampleOut` to 0, `squareOut` to 1 and `periodStart` to 0. This holds at power-up and in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| syncRst | input | 1 | Synchronous reset, active high |
| runEn | input | 1 | Advance enable; low freezes the block |
| sampleOut | output | SAMPLE_W | Registered two's complement sine sample |
| squareOut | output | 1 | High when the sample is non-negative |
| periodStart | output | 1 | Marks the output step carrying entry 0 |

## Verification
The bench uses the default parameters: a 1944-entry table with 125 cycles, 12-bit samples and amplitude 2047. Because 125 and 1944 are coprime, every phase of the sine is visited once per period, including the exact peaks of ±2047 and the two exact zeros. More than two full periods run, so the 1943-to-0 wrap, the period strobe and the duty count over a whole period all occur. Stretches with the enable toggling, and a reset in the middle of a run, check the hold behaviour and the two-step pipeline fill.

// File: rtl/sine_synth_pkg.sv
package sine_synth_pkg;

  typedef struct packed {
    logic advance;   // pipeline moves this cycle
    logic atOrigin;  // address currently selects entry 0
  } stepStrobe_t;

  // Q30 fixed-point angle constants
  localparam longint TWO_PI_Q  = 64'sd6746518852;
  localparam longint PI_Q      = 64'sd3373259426;
  localparam longint HALF_PI_Q = 64'sd1686629713;

  // Integer-only sine evaluation used to build the table at elaboration.
  function automatic int sineEntry(input int n, input int tableLen,
                                   input int cycles, input int amp);
    longint k;
    longint x;
    longint t;
    longint acc;
    longint mag;
    bit     neg;
    k   = (longint'(cycles) * longint'(n)) % longint'(tableLen);
    x   = (k * TWO_PI_Q) / longint'(tableLen);
    neg = 1'b0;
    if (x > PI_Q) begin
      neg = 1'b1;
      x   = x - PI_Q;
    end
    if (x > HALF_PI_Q) x = PI_Q - x;
    acc = x;
    t   = x;
    for (int i = 1; i <= 7; i++) begin
      t = ((((t * x) >>> 30) * x) >>> 30) / longint'((2 * i) * (2 * i + 1));
      if (i % 2 == 1) acc = acc - t;
      else            acc = acc + t;
    end
    mag = (acc * longint'(amp) + 64'sd536870912) >>> 30;
    return neg ? -int'(mag) : int'(mag);
  endfunction

endpackage

// File: rtl/sine_seq_ctrl.sv
module sine_seq_ctrl
  import sine_synth_pkg::*;
#(
  parameter int TABLE_LEN = 1944,
  parameter int ADDR_W    = $clog2(TABLE_LEN)
) (
  input  logic              clk,
  input  logic              syncRst,
  input  logic              runEn,
  output logic [ADDR_W-1:0] tableAddr,
  output stepStrobe_t       strobes
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(TABLE_LEN - 1);

  always_ff @(posedge clk) begin
    if (syncRst) begin
      tableAddr <= '0;
    end else if (runEn) begin
      tableAddr <= (tableAddr == LAST_ADDR) ? '0 : tableAddr + 1'b1;
    end
  end

  always_comb begin
    strobes.advance  = runEn;
    strobes.atOrigin = (tableAddr == '0);
  end

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (syncRst)
    tableAddr <= LAST_ADDR);                                          // R2
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (syncRst)
    (runEn && tableAddr == LAST_ADDR) |=> (tableAddr == '0));         // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (syncRst)
    (runEn && tableAddr != LAST_ADDR) |=> (tableAddr == $past(tableAddr) + 1'b1)); // R1
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (syncRst)
    !runEn |=> $stable(tableAddr));                                   // R7

endmodule

// File: rtl/sine_rom_path.sv
module sine_rom_path
  import sine_synth_pkg::*;
#(
  parameter int TABLE_LEN = 1944,
  parameter int CYCLES    = 125,
  parameter int SAMPLE_W  = 12,
  parameter int AMPLITUDE = 2047,
  parameter int ADDR_W    = $clog2(TABLE_LEN)
) (
  input  logic                clk,
  input  logic                syncRst,
  input  logic [ADDR_W-1:0]   tableAddr,
  input  stepStrobe_t         strobes,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                squareOut,
  output logic                periodStart
);

  logic [SAMPLE_W-1:0] romWord [TABLE_LEN];
  logic [SAMPLE_W-1:0] romQ;
  logic                originQ;

  for (genvar gi = 0; gi < TABLE_LEN; gi++) begin : g_rom
    localparam int ENTRY = sineEntry(gi, TABLE_LEN, CYCLES, AMPLITUDE);
    assign romWord[gi] = ENTRY[SAMPLE_W-1:0];
  end

  // Stage 1: registered table read; stage 2: output retime register.
  always_ff @(posedge clk) begin
    if (syncRst) begin
      romQ        <= '0;
      originQ     <= 1'b0;
      sampleOut   <= '0;
      squareOut   <= 1'b1;
      periodStart <= 1'b0;
    end else if (strobes.advance) begin
      romQ        <= romWord[tableAddr];
      originQ     <= strobes.atOrigin;
      sampleOut   <= romQ;
      squareOut   <= ~romQ[SAMPLE_W-1];
      periodStart <= originQ;
    end
  end

  AST_SAMPLE_BOUND: assert property (@(posedge clk) disable iff (syncRst)
    ($signed(sampleOut) <= AMPLITUDE) && ($signed(sampleOut) >= -AMPLITUDE)); // R3
  AST_SQUARE_SIGN: assert property (@(posedge clk) disable iff (syncRst)
    squareOut == ($signed(sampleOut) >= 0));                          // R5
  AST_STROBE_ZERO: assert property (@(posedge clk) disable iff (syncRst)
    periodStart |-> (sampleOut == '0));                               // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (syncRst)
    !strobes.advance |=> ($stable(sampleOut) && $stable(periodStart))); // R7

endmodule

// File: rtl/sine_synth_fixed.sv
module sine_synth_fixed
  import sine_synth_pkg::*;
#(
  parameter int TABLE_LEN = 1944,
  parameter int CYCLES    = 125,
  parameter int SAMPLE_W  = 12,
  parameter int AMPLITUDE = 2047
) (
  input  logic                clk,
  input  logic                syncRst,
  input  logic                runEn,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                squareOut,
  output logic                periodStart
);

  localparam int ADDR_W = $clog2(TABLE_LEN);

  logic [ADDR_W-1:0] tableAddr;
  stepStrobe_t       strobes;

  sine_seq_ctrl #(
    .TABLE_LEN(TABLE_LEN),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .clk      (clk),
    .syncRst  (syncRst),
    .runEn    (runEn),
    .tableAddr(tableAddr),
    .strobes  (strobes)
  );

  sine_rom_path #(
    .TABLE_LEN(TABLE_LEN),
    .CYCLES   (CYCLES),
    .SAMPLE_W (SAMPLE_W),
    .AMPLITUDE(AMPLITUDE),
    .ADDR_W   (ADDR_W)
  ) u_path (
    .clk        (clk),
    .syncRst    (syncRst),
    .tableAddr  (tableAddr),
    .strobes    (strobes),
    .sampleOut  (sampleOut),
    .squareOut  (squareOut),
    .periodStart(periodStart)
  );

endmodule

// File: tb/sim_sine_synth_fixed.sv
module sim_sine_synth_fixed;

  localparam int LEN = 1944;
  localparam int CYC = 125;
  localparam int SW  = 12;
  localparam int AMP = 2047;

  logic clk = 1'b0;
  logic syncRst = 1'b1;
  logic runEn = 1'b0;
  logic [SW-1:0] sampleOut;
  logic squareOut;
  logic periodStart;

  always #4 clk = ~clk;

  sine_synth_fixed #(.TABLE_LEN(LEN), .CYCLES(CYC), .SAMPLE_W(SW), .AMPLITUDE(AMP)) u0 (
    .clk(clk), .syncRst(syncRst), .runEn(runEn),
    .sampleOut(sampleOut), .squareOut(squareOut), .periodStart(periodStart)
  );

  int nCompared = 0;
  int nMismatch = 0;
  int expQ[$];
  int nextIdx = 0;
  bit armed = 0;
  bit rstEdge = 0;
  bit enEdge = 0;
  bit finished = 0;
  logic [SW-1:0] prevSample;
  logic prevSquare, prevStrobe;
  int dutyHigh = 0, dutyCount = 0, expHigh = 0;
  bit dutyOn = 0;

  function automatic int expSample(int n);
    real r;
    r = real'(AMP) * $sin(2.0 * 3.14159265358979 * real'(CYC) * real'(n) / real'(LEN));
    if (r >= 0.0) return int'($floor(r + 0.5));
    return -int'($floor(-r + 0.5));
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nCompared++;
    if (!ok) begin
      nMismatch++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: one clock step, pushes the expected entry on an enabled edge
  task automatic step(bit en, bit r);
    @(negedge clk);
    runEn = en;
    syncRst = r;
    @(posedge clk);
    armed = 1;
    if (r) begin
      rstEdge = 1; enEdge = 0;
      expQ.delete();
      nextIdx = 0;
      dutyOn = 0;
    end else begin
      rstEdge = 0; enEdge = en;
      if (en) begin
        expQ.push_back(nextIdx);
        nextIdx = (nextIdx + 1) % LEN;
      end
    end
  endtask

  // monitor: compares outputs away from the clock edge
  always @(negedge clk) begin
    if (armed && !finished) begin
      int got;
      got = int'($signed(sampleOut));
      if (rstEdge) begin
        check(sampleOut == '0, "R8 reset sample", got, 0);
        check(squareOut == 1'b1, "R8 reset square", int'(squareOut), 1);
        check(periodStart == 1'b0, "R8 reset strobe", int'(periodStart), 0);
      end else if (enEdge) begin
        if (expQ.size() >= 2) begin
          int idx, ev, d;
          idx = expQ.pop_front();
          ev = expSample(idx);
          d = got - ev;
          if (ev == 0 || ev == AMP || ev == -AMP)
            check(got == ev, "R3 exact entry (R1 R2 order)", got, ev);
          else
            check(d >= -1 && d <= 1, "R3 entry (R1 R2 order)", got, ev);
          check(squareOut == (got >= 0), "R5 square sign", int'(squareOut), int'(got >= 0));
          check(periodStart == (idx == 0), "R6 period strobe", int'(periodStart), int'(idx == 0));
          if (idx == 0) begin dutyOn = 1; dutyHigh = 0; dutyCount = 0; end
          if (dutyOn) begin
            dutyCount++;
            if (squareOut) dutyHigh++;
            if (idx == LEN - 1) begin
              check(dutyCount == LEN && dutyHigh == expHigh, "R5 period duty", dutyHigh, expHigh);
              dutyOn = 0;
            end
          end
        end else begin
          check(sampleOut == '0 && periodStart == 1'b0, "R4 pipeline fill", got, 0);
        end
      end else begin
        check(sampleOut == prevSample, "R7 hold sample", got, int'($signed(prevSample)));
        check(squareOut == prevSquare && periodStart == prevStrobe, "R7 hold flags",
              int'({squareOut, periodStart}), int'({prevSquare, prevStrobe}));
      end
      prevSample = sampleOut;
      prevSquare = squareOut;
      prevStrobe = periodStart;
    end
  end

  task automatic finish();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  endtask

  initial begin
    #(100000 * 8);
    nCompared++;
    nMismatch++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin
    for (int n = 0; n < LEN; n++) if (expSample(n) >= 0) expHigh++;
    // R8: power-up reset
    repeat (3) step(1'b0, 1'b1);
    // R7: idle after reset holds reset values
    repeat (4) step(1'b0, 1'b0);
    // R1 R2 R3 R4 R6: long enabled run across the wrap
    repeat (2100) step(1'b1, 1'b0);
    // R7: toggling enable
    for (int i = 0; i < 300; i++) step(i % 3 != 0, 1'b0);
    // R5: full period with duty count
    repeat (2200) step(1'b1, 1'b0);
    // R8: reset mid-run, then R4 fill and restart from entry 0
    repeat (2) step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    repeat (40) step(1'b1, 1'b0);
    for (int i = 0; i < 50; i++) step(i % 2 == 0, 1'b0);
    repeat (4) step(1'b1, 1'b0);
    @(negedge clk);
    @(negedge clk);
    finish();
  end

endmodule